// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block takes one DMA transfer at a time from a requester: a byte start address, a byte length, a kind code and, for stores, the write bytes. It cuts the transfer into memory requests that never span a cache-line boundary. It sends these chunks, one at a time, to a downstream port that works on whole lines. The first chunk keeps the start address's position inside its line and is clipped at the line end. Every later chunk starts on a line boundary.

A chunk of a store advances when the memory acknowledges it. A chunk of a load advances when its line data returns, and the returned bytes are packed into an internal buffer. When the last chunk finishes, the block raises a one-cycle completion pulse carrying the transfer's ID, and it becomes ready for the next transfer. Every accepted transfer receives the next value of an incrementing ID, reported one cycle after acceptance.

Top module: `dma_line_seq`

## Requirements
- R1: While idle (`req_ready` high), a request with kind 1 (load) or 2 (store) and a length from 1 to MAX_LEN is accepted on a clock edge. On the next cycle `acc_ok` pulses with `acc_id`, `req_ready` is low and `mem_valid` is high.
- R2: A request with any other kind (0 and 3..7: null, fetch, locked and atomic forms), or with length 0 or above MAX_LEN, is refused. `rej` pulses the next cycle, no chunk is issued and `req_ready` stays high.
- R3: While a transfer is in progress, `req_ready` is low and a presented request has no effect: no `acc_ok`, no `rej`, and no ID is used up.
- R4: The first chunk has `mem_off` = start address mod LINE_BYTES, `mem_len` = min(length, LINE_BYTES − offset), `mem_addr` = start address and `mem_line_addr` = start address with the offset bits cleared.
- R5: Each later chunk has `mem_addr` = start + bytes completed, which is line-aligned. It has `mem_off` = 0 and `mem_len` = min(remaining bytes, LINE_BYTES).
- R6: Only one chunk is outstanding at a time. `mem_valid` and all chunk fields stay stable until `mem_ready`. After the handshake, `mem_valid` stays low until the chunk's response arrives, and the next chunk is presented on the cycle after that response.
- R7: `mem_write` is 1 for store transfers and 0 for load transfers. For a store chunk, `mem_wdata` byte `off+j` holds transfer byte `completed+j` for j < `mem_len`, and all other bytes are zero.
- R8: For a load chunk, bytes `mem_off .. mem_off+mem_len−1` of `mem_rdata` are written to `rd_data` bytes `completed .. completed+mem_len−1`. At completion, `rd_data` holds the whole transfer, with byte i at bit position 8·i.
- R9: On the cycle after the response that brings the completed count to the length, `done` pulses for one cycle with `done_id` equal to the transfer's ID, and `req_ready` is high again.
- R10: A response of the wrong kind while a chunk is outstanding pulses `proto_err` on the next cycle and is otherwise ignored. The wrong kind is `mem_rvalid` during a store or `mem_ack` during a load.
- R11: IDs start at 0 after reset and increase by one for each accepted transfer. Refused requests do not consume an ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Idle, able to take a transfer |
| req_kind | input | 3 | Request kind; 1 load, 2 store, others refused |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte length |
| req_wdata | input | MAX_LEN*8 | Store bytes, byte i at bits 8i+7:8i |
| acc_ok | output | 1 | Acceptance pulse |
| acc_id | output | ID_W | ID of the accepted transfer |
| rej | output | 1 | Refusal pulse |
| mem_valid | output | 1 | Chunk request present |
| mem_ready | input | 1 | Memory takes the chunk |
| mem_write | output | 1 | 1 store chunk, 0 load chunk |
| mem_addr | output | ADDR_W | Full byte address of the chunk |
| mem_line_addr | output | ADDR_W | Line-aligned address |
| mem_off | output | OFF_W | Offset inside the line |
| mem_len | output | OFF_W+1 | Chunk byte count |
| mem_wdata | output | LINE_BYTES*8 | Store bytes placed at offset |
| mem_ack | input | 1 | Store chunk acknowledgement |
| mem_rvalid | input | 1 | Load chunk data return |
| mem_rdata | input | LINE_BYTES*8 | Returned line data |
| done | output | 1 | Transfer completion pulse |
| done_id | output | ID_W | ID of the completed transfer |
| proto_err | output | 1 | Wrong-kind response pulse |
| rd_data | output | MAX_LEN*8 | Gathered transfer bytes |

## Verification
Directed transfers vary where the start address sits in its line and how the length relates to the line. An aligned one-line load shows that no clipping happens. A short load that starts in mid-line and ends inside the same line separates the "fits" case from the clipped case. An unaligned store spanning three lines, and an unaligned load of maximum length spanning five, check the first-chunk clipping, the aligned follow-on chunks and the short tail. Stalled handshakes, requests arriving while busy, wrong-kind responses and refused kinds and lengths check that nothing moves when it must not, and that IDs advance only on acceptance.

// File: rtl/dma_line_seq.sv
module dma_line_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int MAX_LEN    = 64,
  parameter int ID_W       = 8,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int CL_W  = OFF_W + 1,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int IDX_W = $clog2(MAX_LEN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_kind,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [MAX_LEN*8-1:0]    req_wdata,
  output logic                    acc_ok,
  output logic [ID_W-1:0]         acc_id,
  output logic                    rej,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_write,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_line_addr,
  output logic [OFF_W-1:0]        mem_off,
  output logic [CL_W-1:0]         mem_len,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic                    mem_rvalid,
  input  logic [LINE_BYTES*8-1:0] mem_rdata,
  output logic                    done,
  output logic [ID_W-1:0]         done_id,
  output logic                    proto_err,
  output logic [MAX_LEN*8-1:0]    rd_data
);

  localparam logic [2:0] KIND_LOAD  = 3'd1;
  localparam logic [2:0] KIND_STORE = 3'd2;

  logic              busy, wr;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  tot, cpl, rem, new_cpl;
  logic [ID_W-1:0]   cur_id, nxt_id;
  logic [7:0]        buf_q [MAX_LEN];
  logic [7:0]        rd_byte [LINE_BYTES];
  logic [7:0]        rd_src [MAX_LEN];
  logic              in_chunk [MAX_LEN];
  logic [OFF_W-1:0]  off_c;
  logic [CL_W-1:0]   room, clen;
  logic              first, legal, take, waiting, rsp_ok, rsp_bad;

  assign req_ready = !busy;
  assign take      = req_valid && !busy;
  assign legal     = (req_kind == KIND_LOAD || req_kind == KIND_STORE) &&
                     (req_len != '0) && (int'(req_len) <= MAX_LEN);

  assign first   = (cpl == '0);
  assign off_c   = first ? base[OFF_W-1:0] : '0;
  assign room    = CL_W'(LINE_BYTES) - CL_W'(off_c);
  assign rem     = tot - cpl;
  assign clen    = (int'(rem) < int'(room)) ? CL_W'(rem) : room;
  assign new_cpl = cpl + LEN_W'(clen);

  assign mem_addr      = base + ADDR_W'(cpl);
  assign mem_line_addr = {mem_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_off       = off_c;
  assign mem_len       = clen;
  assign mem_write     = wr;

  assign waiting = busy && !mem_valid;
  assign rsp_ok  = waiting && (wr ? mem_ack : mem_rvalid);
  assign rsp_bad = waiting && (wr ? mem_rvalid : mem_ack);

  for (genvar j = 0; j < LINE_BYTES; j++) begin : g_line
    assign rd_byte[j] = mem_rdata[8*j +: 8];
    assign mem_wdata[8*j +: 8] =
      (j >= int'(off_c) && j < int'(off_c) + int'(clen))
        ? buf_q[IDX_W'(int'(cpl) + j - int'(off_c))] : 8'h00;
  end

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_buf
    assign in_chunk[i] = (i >= int'(cpl)) && (i < int'(cpl) + int'(clen));
    assign rd_src[i]   = rd_byte[OFF_W'(i - int'(cpl) + int'(off_c))];
    assign rd_data[8*i +: 8] = buf_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wr        <= 1'b0;
      base      <= '0;
      tot       <= '0;
      cpl       <= '0;
      cur_id    <= '0;
      nxt_id    <= '0;
      acc_ok    <= 1'b0;
      acc_id    <= '0;
      rej       <= 1'b0;
      mem_valid <= 1'b0;
      done      <= 1'b0;
      done_id   <= '0;
      proto_err <= 1'b0;
    end else begin
      acc_ok    <= 1'b0;
      rej       <= 1'b0;
      done      <= 1'b0;
      proto_err <= rsp_bad;
      if (take) begin
        if (legal) begin
          busy      <= 1'b1;
          wr        <= (req_kind == KIND_STORE);
          base      <= req_addr;
          tot       <= req_len;
          cpl       <= '0;
          mem_valid <= 1'b1;
          cur_id    <= nxt_id;
          acc_id    <= nxt_id;
          nxt_id    <= nxt_id + 1'b1;
          acc_ok    <= 1'b1;
        end else begin
          rej <= 1'b1;
        end
      end
      if (mem_valid && mem_ready) mem_valid <= 1'b0;
      if (rsp_ok) begin
        cpl <= new_cpl;
        if (new_cpl == tot) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          done_id <= cur_id;
        end else begin
          mem_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_LEN; i++) begin
      if (take && legal && req_kind == KIND_STORE)
        buf_q[i] <= req_wdata[8*i +: 8];
      else if (rsp_ok && !wr && in_chunk[i])
        buf_q[i] <= rd_src[i];
    end
  end

  p_no_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !acc_ok && !rej);

  p_chunk_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len != '0) && (int'(mem_off) + int'(mem_len) <= LINE_BYTES));

  p_later_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !acc_ok && $past(!mem_valid) |-> mem_off == '0 && mem_addr[OFF_W-1:0] == '0);

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_len) &&
                                $stable(mem_wdata));

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid);

  p_done_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !mem_valid);

  p_err_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !done);

  p_id_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> $stable(acc_id));

endmodule

// File: tb/dma_line_seq_bench.sv
`timescale 1ns/1ps
module dma_line_seq_bench;
  localparam int ADDR_W = 16;
  localparam int LINE   = 16;
  localparam int MAXL   = 64;
  localparam int ID_W   = 8;
  localparam int OFF_W  = $clog2(LINE);
  localparam int LEN_W  = $clog2(MAXL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [MAXL*8-1:0] req_wdata = '0;
  logic mem_ready = 1'b0, mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [LINE*8-1:0] mem_rdata = '0;
  logic req_ready, acc_ok, rej, mem_valid, mem_write, done, proto_err;
  logic [ID_W-1:0] acc_id, done_id;
  logic [ADDR_W-1:0] mem_addr, mem_line_addr;
  logic [OFF_W-1:0] mem_off;
  logic [OFF_W:0] mem_len;
  logic [LINE*8-1:0] mem_wdata;
  logic [MAXL*8-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int next_id = 0;
  logic [7:0] mem [256];

  always #4 clk = ~clk;

  dma_line_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .MAX_LEN(MAXL), .ID_W(ID_W)) u_dma_line_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .acc_ok(acc_ok), .acc_id(acc_id), .rej(rej), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_line_addr(mem_line_addr), .mem_off(mem_off), .mem_len(mem_len),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .done_id(done_id), .proto_err(proto_err),
    .rd_data(rd_data));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // kind 1 load, 2 store; stall cycles before mem_ready; optional busy request and wrong response
  task automatic xfer(input logic [2:0] kind, input int addr, input int len, input int stall,
                      input bit poke_busy, input bit bad_rsp);
    int done_b, off, clen, cur, exp_id;
    bit st;
    logic [MAXL*8-1:0] wd;
    st = (kind == 3'd2);
    exp_id = next_id;
    for (int i = 0; i < MAXL; i++) wd[8*i +: 8] = 8'(8'h5A ^ (i * 13) ^ addr);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = ADDR_W'(addr);
    req_len = LEN_W'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(acc_ok == 1'b1 && acc_id == ID_W'(exp_id), "R1 accept pulse/id", acc_id, exp_id);
    chk(req_ready == 1'b0 && mem_valid == 1'b1, "R1 busy and chunk raised",
        {req_ready, mem_valid}, 2'b01);
    chk(mem_write == st, "R7 write flag", mem_write, st);
    next_id++;
    done_b = 0;
    while (done_b < len) begin
      off  = (done_b == 0) ? addr % LINE : 0;
      clen = (len - done_b < LINE - off) ? len - done_b : LINE - off;
      cur  = addr + done_b;
      chk(mem_valid == 1'b1, "R6 chunk presented", mem_valid, 1);
      if (done_b == 0) begin
        chk(mem_off == OFF_W'(off) && int'(mem_len) == clen, "R4 first off/len",
            {mem_off, mem_len}, {OFF_W'(off), (OFF_W+1)'(clen)});
        chk(mem_addr == ADDR_W'(cur) && mem_line_addr == ADDR_W'(cur - off),
            "R4 first addresses", mem_line_addr, cur - off);
      end else begin
        chk(mem_off == '0 && int'(mem_len) == clen && mem_addr == ADDR_W'(cur) &&
            mem_line_addr == ADDR_W'(cur), "R5 later chunk", mem_addr, cur);
      end
      if (st) begin
        for (int j = 0; j < LINE; j++) begin
          logic [7:0] eb;
          eb = (j >= off && j < off + clen) ? wd[8*(done_b + j - off) +: 8] : 8'h00;
          chk(mem_wdata[8*j +: 8] == eb, "R7 write byte", mem_wdata[8*j +: 8], eb);
        end
      end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(mem_valid == 1'b1 && mem_addr == ADDR_W'(cur) && int'(mem_len) == clen,
            "R6 held while stalled", mem_addr, cur);
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      if (poke_busy && done_b == 0) begin
        req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h0; req_len = LEN_W'(4);
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_valid == 1'b0, "R6 no second chunk before response", mem_valid, 0);
      if (poke_busy && done_b == 0)
        chk(acc_ok == 1'b0 && rej == 1'b0 && req_ready == 1'b0, "R3 request ignored while busy",
            {acc_ok, rej, req_ready}, 3'b000);
      if (bad_rsp && done_b == 0) begin
        if (st) mem_rvalid = 1'b1; else mem_ack = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_ack = 1'b0;
        chk(proto_err == 1'b1 && done == 1'b0 && mem_valid == 1'b0,
            "R10 wrong response flagged and ignored", {proto_err, done, mem_valid}, 3'b100);
      end
      if (st) begin
        for (int j = 0; j < clen; j++) mem[(cur + j) & 255] = wd[8*(done_b + j) +: 8];
        mem_ack = 1'b1;
      end else begin
        for (int j = 0; j < LINE; j++) mem_rdata[8*j +: 8] = mem[(cur - off + j) & 255];
        mem_rvalid = 1'b1;
      end
      @(negedge clk);
      mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '1;
      done_b += clen;
      if (done_b < len)
        chk(done == 1'b0 && mem_valid == 1'b1, "R6 next chunk after response",
            {done, mem_valid}, 2'b01);
    end
    chk(done == 1'b1 && done_id == ID_W'(exp_id), "R9 completion pulse/id", done_id, exp_id);
    chk(req_ready == 1'b1 && mem_valid == 1'b0, "R9 idle after completion",
        {req_ready, mem_valid}, 2'b10);
    if (!st) begin
      for (int i = 0; i < len; i++)
        chk(rd_data[8*i +: 8] == mem[(addr + i) & 255], "R8 gathered read byte",
            rd_data[8*i +: 8], mem[(addr + i) & 255]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 single-cycle pulse", done, 0);
  endtask

  task automatic refuse(input logic [2:0] kind, input int len, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = 16'h30; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rej == 1'b1 && acc_ok == 1'b0, tag, {rej, acc_ok}, 2'b10);
    @(negedge clk);
    chk(mem_valid == 1'b0 && req_ready == 1'b1, "R2 no chunk after refusal",
        {mem_valid, req_ready}, 2'b01);
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0 && acc_ok == 1'b0,
        "R1 reset state", {req_ready, mem_valid, done, acc_ok}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(3'd1, 16'h40, 16, 0, 1'b0, 1'b0);   // R4 aligned single full line
    xfer(3'd2, 16'h13, 40, 2, 1'b1, 1'b0);   // R5 R7 three-line unaligned store, R3 busy poke
    xfer(3'd1, 16'h25, 5, 0, 1'b0, 1'b1);    // R4 fits in line, R10 wrong response
    refuse(3'd4, 8, "R2 locked kind refused");
    refuse(3'd0, 8, "R2 null kind refused");
    refuse(3'd1, 0, "R2 zero length refused");
    refuse(3'd2, MAXL + 1, "R2 over-long refused");
    xfer(3'd1, 16'h07, MAXL, 1, 1'b0, 1'b0); // R8 max length, R11 id after refusals
    xfer(3'd1, 16'h13, 40, 0, 1'b0, 1'b0);   // R8 read back stored data
    finish_run();
  end
endmodule